// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This unit produces the two even-parity bits of a 64-bit multiplexed address/data bus: one bit covering the low 32 data bits with the low four command/byte-enable lines, and one bit covering the high 32 data bits with the high four lines. It watches the cycle-frame, initiator-ready and target-ready handshakes to find the address phase and the data phases. From the role (bus initiator or selected target) and the direction, it decides in which cycles it must drive each parity bit and in which cycles it must check the parity bit driven by the other side.

Parity is registered, so each parity bit appears one clock after the bus cycle it protects. Each parity bit has its own output enable, which an external tri-state pad uses. When the unit is the receiving side, it compares the incoming parity bit with its own registered parity. On a mismatch it raises an error pulse on the following clock.

A two-state machine follows the bus. In state `PH_IDLE` no transaction is in progress. A cycle in `PH_IDLE` with the frame signal asserted is the address phase; it takes the transition `ADDR_START` to `PH_DATA` and latches the role, the direction and the 32-bit-only flag. In `PH_DATA` the transition `FINAL_XFER` back to `PH_IDLE` happens on a clock where both ready signals are asserted and the frame signal is already deasserted. Otherwise the machine stays in `PH_DATA` (transition `DATA_WAIT`). `PH_IDLE` with the frame signal deasserted stays put (transition `BUS_QUIET`).

Top module: `pci_par_unit`

## Requirements
- R1: `par_out[0]` equals the XOR of `ad[31:0]` and `cbe_n[3:0]` sampled on the previous clock, so the ones across those lines plus the parity bit add up to an even count.
- R2: `par_out[1]` equals the XOR of `ad[63:32]` and `cbe_n[7:4]` sampled on the previous clock.
- R3: A cycle in `PH_IDLE` with `frame_n` low is the address phase. On the next cycle an initiator (`is_master`=1) enables parity and a target (`is_master`=0) enables none.
- R4: In `PH_DATA`, parity is enabled on the cycle after one with `irdy_n` low when the latched role is initiator and the latched direction is write (`is_write`=1). It is enabled on the cycle after one with `trdy_n` low when the latched role is target and the latched direction is read. In all other data cycles it is not enabled.
- R5: A data phase completes on a clock with `irdy_n` and `trdy_n` both low. Parity stays enabled on the clock after that completion. If `frame_n` is high on that clock, the transaction ends, and nothing is enabled afterwards until a new address phase.
- R6: Role, direction and `only32` are taken only in the address phase. Changes to them during `PH_DATA` have no effect on the enables or on the checking.
- R7: When the unit is the receiving side for a cycle (a target in the address phase, a target on a write with `irdy_n` low, or an initiator on a read with `trdy_n` low), `perr[i]` is high two clocks after that cycle exactly if `par_in[i]` in the following cycle differs from `par_out[i]`. `perr` is low at all other times.
- R8: When `only32` is high in the address phase, `par_oe[1]` stays low and `perr[1]` stays low for the whole transaction.
- R9: A clock with `rst_n` low clears `par_out`, `par_oe`, `perr`, the pending checks and the state machine (back to `PH_IDLE`).
- R10: The machine leaves `PH_DATA` only through `FINAL_XFER`, and it enters `PH_DATA` only through `ADDR_START`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad | input | 64 | Multiplexed address/data bus |
| cbe_n | input | 8 | Command in the address phase, active-low byte enables in data phases; bit 0 = byte 0 |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| is_master | input | 1 | 1 = this unit is the bus initiator for the transaction |
| is_write | input | 1 | 1 = write transaction, 0 = read |
| only32 | input | 1 | 1 = 32-bit-only transfer; upper parity neither driven nor checked |
| par_in | input | 2 | Parity bits received from the bus; bit 0 low half, bit 1 high half |
| par_out | output | 2 | Registered parity bits; bit 0 low half, bit 1 high half |
| par_oe | output | 2 | Output enable of each parity bit |
| perr | output | 2 | Parity mismatch pulse for each half |

## Verification
The assertions assume that the bus follows the handshake. A transaction opens only with a frame assertion seen while the machine is idle. It closes only with a final transfer that has the frame signal deasserted. Role, direction and width may change at any time without meeting any rule. The stimulus opens every transaction with a single address cycle. In wait cycles it asserts at most one of the two ready signals, and it deasserts the frame signal only in the final completing cycle. It also toggles role, direction and width in the middle of data phases, injects random parity errors in every cycle, and applies one reset in the middle of a transaction.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/pci_par_phase_fsm.sv
module pci_par_phase_fsm
    import pci_par_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             is_master,
    input  logic             is_write,
    input  logic             only32,
    output phase_e           phase,
    output logic [LANES-1:0] drive_nxt,
    output logic [LANES-1:0] check_nxt
);
    phase_e phase_q, phase_d;
    logic   mst_q, wr_q, n32_q;
    logic   addr_ph, xfer, drive_base, check_base, wide;

    assign addr_ph = (phase_q == PH_IDLE) && !frame_n;
    assign xfer    = !irdy_n && !trdy_n;
    assign phase   = phase_q;

    // next-state selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (!frame_n) phase_d = PH_DATA;          // ADDR_START
            PH_DATA: if (xfer && frame_n) phase_d = PH_IDLE;   // FINAL_XFER
            default: phase_d = PH_IDLE;
        endcase
    end

    // state register and attributes latched in the address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mst_q   <= 1'b0;
            wr_q    <= 1'b0;
            n32_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (addr_ph) begin
                mst_q <= is_master;
                wr_q  <= is_write;
                n32_q <= only32;
            end
        end
    end

    // output decisions for the coming cycle
    always_comb begin
        drive_base = 1'b0;
        check_base = 1'b0;
        wide       = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (!frame_n) begin
                    drive_base = is_master;
                    check_base = !is_master;
                    wide       = !only32;
                end
            end
            PH_DATA: begin
                wide = !n32_q;
                if (mst_q) begin
                    drive_base = wr_q && !irdy_n;
                    check_base = !wr_q && !trdy_n;
                end else begin
                    drive_base = !wr_q && !trdy_n;
                    check_base = wr_q && !irdy_n;
                end
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_gate
        if (g == 0) begin : g_base
            assign drive_nxt[g] = drive_base;
            assign check_nxt[g] = check_base;
        end else begin : g_wide
            assign drive_nxt[g] = drive_base && wide;
            assign check_nxt[g] = check_base && wide;
        end
    end

    AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !frame_n) |=> (phase_q == PH_DATA)); // R10
    AST_FINAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && xfer && frame_n) |=> (phase_q == PH_IDLE)); // R10
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && !(xfer && frame_n)) |=> (phase_q == PH_DATA)); // R10
    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA && $past(phase_q) == PH_DATA) |-> ($stable(mst_q) && $stable(wr_q) && $stable(n32_q))); // R6
endmodule

// File: rtl/pci_par_lane.sv
module pci_par_lane #(
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_s,
    input  logic [BW-1:0] be_s,
    input  logic          drive_nxt,
    input  logic          check_nxt,
    input  logic          par_in,
    output logic          par_out,
    output logic          par_oe,
    output logic          perr
);
    logic par_q, oe_q, chk_q, err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
            chk_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            par_q <= ^{ad_s, be_s};
            oe_q  <= drive_nxt;
            chk_q <= check_nxt;
            err_q <= chk_q && (par_in != par_q);
        end
    end

    assign par_out = par_q;
    assign par_oe  = oe_q;
    assign perr    = err_q;

    AST_ERR_NOT_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        perr |-> !$past(par_oe)); // R7
    AST_ERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        perr |-> $past(check_nxt, 2)); // R7
endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
    import pci_par_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int BE_W   = 4,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*LANE_W-1:0]  ad,
    input  logic [LANES*BE_W-1:0]    cbe_n,
    input  logic                     frame_n,
    input  logic                     irdy_n,
    input  logic                     trdy_n,
    input  logic                     is_master,
    input  logic                     is_write,
    input  logic                     only32,
    input  logic [LANES-1:0]         par_in,
    output logic [LANES-1:0]         par_out,
    output logic [LANES-1:0]         par_oe,
    output logic [LANES-1:0]         perr
);
    phase_e           phase;
    logic [LANES-1:0] drive_nxt, check_nxt;

    pci_par_phase_fsm #(.LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .trdy_n    (trdy_n),
        .is_master (is_master),
        .is_write  (is_write),
        .only32    (only32),
        .phase     (phase),
        .drive_nxt (drive_nxt),
        .check_nxt (check_nxt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pci_par_lane #(.DW(LANE_W), .BW(BE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ad_s      (ad[g*LANE_W +: LANE_W]),
            .be_s      (cbe_n[g*BE_W +: BE_W]),
            .drive_nxt (drive_nxt[g]),
            .check_nxt (check_nxt[g]),
            .par_in    (par_in[g]),
            .par_out   (par_out[g]),
            .par_oe    (par_oe[g]),
            .perr      (perr[g])
        );
    end

    AST_LOW_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe[0] |-> (par_out[0] == ^{$past(ad[LANE_W-1:0]), $past(cbe_n[BE_W-1:0])})); // R1
    AST_TARGET_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !frame_n && !is_master) |=> (par_oe == '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && frame_n) |=> (par_oe == '0)); // R5
    AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !frame_n && only32) |=> !par_oe[LANES-1]); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (par_oe == '0 && perr == '0 && par_out == '0)); // R9
endmodule

// File: tb/pci_par_unit_tb_top.sv
module pci_par_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = '1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        is_master = 1'b0, is_write = 1'b0, only32 = 1'b0;
    logic [1:0]  par_in = '0;
    logic [1:0]  par_out, par_oe, perr;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // reference model state
    bit       m_busy = 0, m_mst = 0, m_wr = 0, m_n32 = 0;
    bit [1:0] prev_rcv = '0, prev_par = '0;

    always #10 clk = ~clk;

    pci_par_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad(ad), .cbe_n(cbe_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .is_master(is_master), .is_write(is_write), .only32(only32),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .perr(perr)
    );

    task automatic chk1(input string req, input string what, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // predict the outputs after the coming edge, advance the model, then compare
    task automatic step();
        bit       addr, drv, rcv, wide, flip;
        bit [1:0] e_oe, e_par, e_perr;
        string    ctx;
        e_par[0] = ^{ad[31:0], cbe_n[3:0]};
        e_par[1] = ^{ad[63:32], cbe_n[7:4]};
        drv = 0; rcv = 0; wide = 0; flip = 0;
        addr = !m_busy && !frame_n;
        if (addr) begin
            drv = is_master; rcv = !is_master; wide = !only32;
            ctx = "R3";
        end else if (m_busy) begin
            wide = !m_n32;
            if (m_mst) begin drv = m_wr && !irdy_n;  rcv = !m_wr && !trdy_n; end
            else       begin drv = !m_wr && !trdy_n; rcv = m_wr && !irdy_n;  end
            flip = (is_master != m_mst) || (is_write != m_wr) || (only32 != m_n32);
            ctx = (!irdy_n && !trdy_n) ? "R5" : (flip ? "R6" : "R4");
        end else begin
            ctx = "R10";
        end
        e_oe   = {drv && wide, drv};
        e_perr = {prev_rcv[1] && (par_in[1] != prev_par[1]),
                  prev_rcv[0] && (par_in[0] != prev_par[0])};
        if (!rst_n) begin
            e_oe = '0; e_par = '0; e_perr = '0;
            m_busy = 0; m_mst = 0; m_wr = 0; m_n32 = 0;
            prev_rcv = '0; prev_par = '0;
            ctx = "R9";
        end else begin
            prev_rcv = {rcv && wide, rcv};
            prev_par = e_par;
            if (addr) begin
                m_busy = 1; m_mst = is_master; m_wr = is_write; m_n32 = only32;
            end else if (m_busy && !irdy_n && !trdy_n && frame_n) begin
                m_busy = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk1(rst_n ? "R1" : "R9", "par_out[0]", par_out[0], e_par[0]);
        chk1(rst_n ? "R2" : "R9", "par_out[1]", par_out[1], e_par[1]);
        chk1(ctx, "par_oe[0]", par_oe[0], e_oe[0]);
        chk1(rst_n ? "R8" : "R9", "par_oe[1]", par_oe[1], e_oe[1]);
        chk1(rst_n ? "R7" : "R9", "perr[0]", perr[0], e_perr[0]);
        chk1(rst_n ? "R8" : "R9", "perr[1] R7", perr[1], e_perr[1]);
    endtask

    task automatic cyc(input logic f, input logic i, input logic t);
        ad      = {$urandom, $urandom};
        cbe_n   = 8'($urandom);
        par_in  = prev_par ^ {($urandom % 5 == 0), ($urandom % 5 == 0)};
        frame_n = f; irdy_n = i; trdy_n = t;
        step();
    endtask

    task automatic txn(input logic mst, input logic wr, input logic n32, input int nd, input bit churn);
        is_master = mst; is_write = wr; only32 = n32;
        cyc(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < nd; k++) begin
            int waits = $urandom % 3;
            for (int w = 0; w < waits; w++) begin
                logic ir = 1'($urandom % 2);
                logic tr = ir ? 1'($urandom % 2) : 1'b1;
                if (churn && ($urandom % 2 == 0)) begin
                    is_master = ~is_master; is_write = ~is_write; only32 = ~only32;
                end
                cyc(1'b0, ir, tr);
            end
            cyc((k == nd - 1), 1'b0, 1'b0);
        end
    endtask

    initial begin
        cyc(1'b1, 1'b1, 1'b1);                 // R9 reset
        cyc(1'b1, 1'b1, 1'b1);
        rst_n = 1'b1;
        repeat (3) cyc(1'b1, 1'b1, 1'b1);      // R10 quiet bus
        txn(1'b1, 1'b1, 1'b0, 3, 0);           // R3 R4 initiator write
        cyc(1'b1, 1'b1, 1'b1);
        txn(1'b1, 1'b0, 1'b0, 3, 0);           // R7 initiator read
        txn(1'b0, 1'b0, 1'b0, 2, 0);           // R4 target read, back to back
        cyc(1'b1, 1'b1, 1'b1);
        txn(1'b0, 1'b1, 1'b0, 3, 0);           // R7 target write
        txn(1'b1, 1'b1, 1'b1, 2, 0);           // R8 narrow write
        txn(1'b0, 1'b1, 1'b1, 2, 0);           // R8 narrow target write
        txn(1'b1, 1'b0, 1'b0, 4, 1);           // R6 attribute churn
        // R9 reset in the middle of a data phase
        is_master = 1'b1; is_write = 1'b1; only32 = 1'b0;
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        repeat (2) cyc(1'b1, 1'b1, 1'b1);
        for (int n = 0; n < 300; n++) begin
            txn(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 3 == 0),
                1 + ($urandom % 4), 1'($urandom % 2));
            repeat ($urandom % 3) cyc(1'b1, 1'b1, 1'b1);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule